// File: doc/BRIEF.md
# Sixteen-Bit PWM and Capture Timer

This block is a 16-bit up-counting timer that software controls through a byte-wide register port. In PWM mode it compares the running count with a 16-bit compare value and drives a complementary output pair. A programmable dead time is inserted before each rising edge of either output, so the two outputs are never high together. In capture mode the same 16-bit compare/capture register pair latches the running count when a qualified edge arrives on a synchronised input pin.

A single interrupt line pulses for one clock on each selected event. The events are reload, capture or both. A status flag in control register 0 tells software whether the latest interrupt was raised by a capture. The compare value is written high byte first. The low-byte write commits all 16 bits at once, so the comparator never acts on a half-written value.

The register port is plain control access with no handshake: a write is taken on any clock edge where `wr_en` is high, and `rd_data` shows the addressed register combinationally. No interface carries a data stream, so there is no back-pressure.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset every register reads 0 at addresses 0 to 7, `irq` is 0 and `pwm_p` is 0.
- R2: Register map. Address 0 is control 0: {bit7 mode high bit, bits6:5 interrupt source, bits4:2 dead-time code, bit1 reads 0, bit0 capture status}. Address 1 is control 1: {bit7 enable, bit6 polarity, bit5 falling-edge select, bits4:3 read 0, bits2:0 mode low bits}. Addresses 2/3 hold the compare/capture high/low bytes. Addresses 4/5 hold the reload high/low bytes. Addresses 6/7 are the read-only count high/low bytes. The mode is {control0[7], control1[2:0]}: 4'b0011 selects PWM, 4'b0100 selects capture, and any other value counts only.
- R3: While enabled, the count goes to 1 on each clock edge where it is at or above the reload value, and this raises a reload event. Otherwise it steps up by 1. While disabled it holds.
- R4: In PWM mode the internal PWM level toggles on the edge after the count equals the compare value. It returns to 0 on every reload event. With reload R and compare C (0 < C < R) it is high for R-C counts of each period.
- R5: `pwm_p` follows the PWM level XOR the polarity bit, and `pwm_n` follows its complement. Both pass through one register and the dead-time stage.
- R6: Each output falls one clock after its target falls. It rises 2^code clocks later than it would with code 0, and code 0 adds no delay. `pwm_p` and `pwm_n` are never high together.
- R7: In capture mode, a rising edge (or a falling edge when bit 5 of control 1 is set) on `cap_in` passes a 2-flop synchroniser. The count that is present two clocks after the pin changes is then loaded into the compare/capture pair. An edge of the other direction captures nothing. A capture takes priority over a bus write to the low byte in the same cycle.
- R8: Interrupt source code 0x enables both reload and capture, 10 enables capture only, and 11 enables reload only. `irq` is high for one clock after each edge at which an enabled event happens.
- R9: When an interrupt is raised, the status bit becomes 1 if a capture contributed to it, including a capture that coincides with a reload, and 0 otherwise. It holds between interrupts. Bus writes to it have no effect.
- R10: A write to the compare high byte is staged only. Reads and the comparator keep the old 16-bit value until the low-byte write loads {staged high, new low}.
- R11: In a count-only mode the PWM level stays 0, so with polarity 0 `pwm_p` stays low and `pwm_n` stays high. No capture is taken in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data of addressed register |
| cap_in | input | 1 | Asynchronous capture pin |
| pwm_p | output | 1 | PWM true output |
| pwm_n | output | 1 | PWM complementary output |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
A capture and a reload can happen on the same clock edge, and both then feed one interrupt and one status flag. The bench polls the count and drives the capture pin when the count is two below the reload value. With that timing the synchronised edge lands on the wrapping edge. The bench then expects a single interrupt pulse, a status of 1 and a captured value equal to the reload value. The next reload, which has no capture, must bring the status back to 0, and a capture with the capture source masked must leave both the interrupt and the status untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DB_W   = 3;
  localparam int SYNC_N = 2;

  localparam logic [ADDR_W-1:0] A_CTL0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_H = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_L = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_H = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_L = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd7;

  localparam logic [3:0] MODE_PWM = 4'b0011;
  localparam logic [3:0] MODE_CAP = 4'b0100;

  localparam logic [1:0] SRC_CAP_ONLY = 2'b10;
  localparam logic [1:0] SRC_RLD_ONLY = 2'b11;

  typedef struct packed {
    logic            mode_hi;
    logic [1:0]      irq_src;
    logic [DB_W-1:0] db;
    logic            en;
    logic            pol;
    logic            edge_fall;
    logic [2:0]      mode_lo;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wr_data,
  input  logic          cap_load,
  input  logic [CW-1:0] cap_value,
  input  logic          irq_raise,
  input  logic          irq_from_cap,
  input  logic [CW-1:0] cnt,
  output tmr_cfg_t      cfg,
  output logic [CW-1:0] cmp_val,
  output logic [CW-1:0] rld_val,
  output logic [BW-1:0] rd_data
);
  localparam int HI_W = CW - BW;

  tmr_cfg_t        cfg_q;
  logic [HI_W-1:0] stage_hi;
  logic [CW-1:0]   cmp_q;
  logic [CW-1:0]   rld_q;
  logic            flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      stage_hi <= '0;
      cmp_q    <= '0;
      rld_q    <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTL0: begin
            cfg_q.mode_hi <= wr_data[7];
            cfg_q.irq_src <= wr_data[6:5];
            cfg_q.db      <= wr_data[4:2];
          end
          A_CTL1: begin
            cfg_q.en        <= wr_data[7];
            cfg_q.pol       <= wr_data[6];
            cfg_q.edge_fall <= wr_data[5];
            cfg_q.mode_lo   <= wr_data[2:0];
          end
          A_CMP_H: stage_hi <= wr_data[HI_W-1:0];
          A_CMP_L: if (!cap_load) cmp_q <= {stage_hi, wr_data};
          A_RLD_H: rld_q[CW-1:BW] <= wr_data[HI_W-1:0];
          A_RLD_L: rld_q[BW-1:0]  <= wr_data;
          default: ;
        endcase
      end
      if (cap_load) cmp_q <= cap_value;
      if (irq_raise) flag_q <= irq_from_cap;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTL0:  rd_data = {cfg_q.mode_hi, cfg_q.irq_src, cfg_q.db, 1'b0, flag_q};
      A_CTL1:  rd_data = {cfg_q.en, cfg_q.pol, cfg_q.edge_fall, 2'b00, cfg_q.mode_lo};
      A_CMP_H: rd_data = cmp_q[CW-1:BW];
      A_CMP_L: rd_data = cmp_q[BW-1:0];
      A_RLD_H: rd_data = rld_q[CW-1:BW];
      A_RLD_L: rd_data = rld_q[BW-1:0];
      A_CNT_H: rd_data = cnt[CW-1:BW];
      A_CNT_L: rd_data = cnt[BW-1:0];
      default: rd_data = '0;
    endcase
  end

  assign cfg     = cfg_q;
  assign cmp_val = cmp_q;
  assign rld_val = rld_q;

  // R10: a high-byte write alone never moves the live compare value
  a_r10_half_write_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMP_H && !cap_load) |=> $stable(cmp_q));
  // R9: status only moves when an interrupt is raised
  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_raise |=> $stable(flag_q));
  // R7: a capture lands the count in the shared pair
  a_r7_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> cmp_q == $past(cap_value));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;

  assign wrap = run && (cnt_q >= reload_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= CW'(1);
    else if (run)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt = cnt_q;

  // R3: reload restarts at one
  a_r3_wrap_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == CW'(1));
  // R3: ordinary steps add one, idle holds
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> cnt_q == $past(cnt_q) + CW'(1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_pwm_core.sv
module tmr_pwm_core
  import tmr_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp_val,
  output logic          level
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lvl_q <= 1'b0;
    else if (!active || wrap) lvl_q <= 1'b0;
    else if (cnt == cmp_val)  lvl_q <= ~lvl_q;
  end

  assign level = lvl_q;

  // R4: every reload returns the level to its start value
  a_r4_start_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wrap) |=> !lvl_q);
  // R4: without a match the level is held
  a_r4_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wrap && cnt != cmp_val) |=> $stable(lvl_q));
  // R11: outside PWM mode the level stays at start value
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !lvl_q);
endmodule

// File: rtl/tmr_deadband.sv
module tmr_deadband
  import tmr_pkg::*;
#(
  parameter int DBW = DB_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DBW-1:0] db,
  input  logic           tgt,
  output logic           out
);
  localparam int WW = 1 << DBW;

  logic [WW-1:0] dly;
  logic [WW-1:0] wait_q;
  logic          out_q;

  always_comb dly = (db == '0) ? '0 : (WW'(1) << db);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      wait_q <= '0;
    end else if (!tgt) begin
      out_q  <= 1'b0;
      wait_q <= '0;
    end else if (!out_q) begin
      if (wait_q >= dly) out_q <= 1'b1;
      else               wait_q <= wait_q + WW'(1);
    end
  end

  assign out = out_q;

  // R6: a falling target drops the output on the next edge
  a_r6_drop_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt |=> !out_q);
  // R6: the output cannot rise before the dead time has elapsed
  a_r6_rise_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt && !out_q && wait_q < dly) |=> !out_q);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int SN = SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  input  logic arm,
  output logic hit
);
  logic [SN:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SN-1:0], pin};
  end

  logic rise_seen;
  logic fall_seen;
  assign rise_seen = sync_q[SN-1] & ~sync_q[SN];
  assign fall_seen = ~sync_q[SN-1] & sync_q[SN];
  assign hit = arm && (fall_sel ? fall_seen : rise_seen);

  // R7: a hit always corresponds to an edge of the chosen direction
  a_r7_hit_dir: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fall_sel ? (sync_q[SN] && !sync_q[SN-1]) : (!sync_q[SN] && sync_q[SN-1])));
endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              cap_in,
  output logic              pwm_p,
  output logic              pwm_n,
  output logic              irq
);
  tmr_cfg_t         cfg;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] rld_val;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             cap_hit;
  logic             level;
  logic [3:0]       mode;
  logic             pwm_act;
  logic             cap_arm;
  logic             cap_raise;
  logic             rld_raise;
  logic             raise;
  logic             irq_q;

  assign mode    = {cfg.mode_hi, cfg.mode_lo};
  assign pwm_act = cfg.en && (mode == MODE_PWM);
  assign cap_arm = cfg.en && (mode == MODE_CAP);

  assign cap_raise = cap_hit && (cfg.irq_src != SRC_RLD_ONLY);
  assign rld_raise = wrap && (cfg.irq_src != SRC_CAP_ONLY);
  assign raise     = cap_raise || rld_raise;

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cap_load(cap_hit), .cap_value(cnt), .irq_raise(raise),
    .irq_from_cap(cap_raise), .cnt(cnt), .cfg(cfg), .cmp_val(cmp_val),
    .rld_val(rld_val), .rd_data(rd_data)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg.en), .reload_val(rld_val),
    .cnt(cnt), .wrap(wrap)
  );

  tmr_pwm_core u_pwm (
    .clk(clk), .rst_n(rst_n), .active(pwm_act), .wrap(wrap), .cnt(cnt),
    .cmp_val(cmp_val), .level(level)
  );

  tmr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .fall_sel(cfg.edge_fall),
    .arm(cap_arm), .hit(cap_hit)
  );

  logic [1:0] tgt;
  logic [1:0] outs;
  assign tgt[0] = level ^ cfg.pol;
  assign tgt[1] = ~tgt[0];

  for (genvar g = 0; g < 2; g++) begin : g_chan
    tmr_deadband u_db (
      .clk(clk), .rst_n(rst_n), .db(cfg.db), .tgt(tgt[g]), .out(outs[g])
    );
  end

  assign pwm_p = outs[0];
  assign pwm_n = outs[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= raise;
  end
  assign irq = irq_q;

  // R6: complementary outputs never overlap
  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_p && pwm_n));
  // R8: capture-only source ignores a lone reload
  a_r8_cap_only_src: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.irq_src == SRC_CAP_ONLY && !cap_hit) |=> !irq);
  // R8: reload-only source ignores a lone capture
  a_r8_rld_only_src: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.irq_src == SRC_RLD_ONLY && !wrap) |=> !irq);
  // R11: no capture outside capture mode
  a_r11_no_cap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_arm |-> !cap_hit);
endmodule

// File: tb/pwm_cap_timer_bench.sv
`timescale 1ns/1ps
module pwm_cap_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       cap_in = 1'b0;
  logic       pwm_p, pwm_n, irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwm_cap_timer u_pwm_cap_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cap_in(cap_in), .pwm_p(pwm_p), .pwm_n(pwm_n), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #0.25; d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] ahi, output int v);
    logic [7:0] h, l;
    rd(ahi, h);
    rd(ahi + 3'd1, l);
    v = {h, l};
  endtask

  task automatic test_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reset reg %0d", a), d, 0);
    end
    chk("R1 reset irq", irq, 0);
    chk("R1 reset pwm_p", pwm_p, 0);
  endtask

  task automatic test_staging();
    int v;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    rd16(3'd2, v); chk("R10 full compare write", v, 16'h1234);
    wr(3'd2, 8'h56);
    rd16(3'd2, v); chk("R10 high byte staged only", v, 16'h1234);
    wr(3'd3, 8'h78);
    rd16(3'd2, v); chk("R10 low byte commits", v, 16'h5678);
    wr(3'd1, 8'hA5);
    rd(3'd1, d); chk("R2 ctl1 fields", d, 8'hA5 & 8'hE7);
    wr(3'd1, 8'h00);
  endtask

  task automatic test_counter();
    int c, prev;
    int pwm_hi = 0;
    wr(3'd4, 8'h00); wr(3'd5, 8'h05);
    wr(3'd0, 8'h60);            // reload-only interrupts
    wr(3'd1, 8'h80);            // enable, count-only mode
    @(negedge clk);
    rd16(3'd6, prev);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R8 reload irq", irq, (prev >= 5) ? 1 : 0);
      rd16(3'd6, c);
      chk("R3 count step", c, (prev >= 5) ? 1 : prev + 1);
      if (pwm_p) pwm_hi++;
      prev = c;
    end
    chk("R11 count-only keeps pwm_p low", pwm_hi, 0);
    wr(3'd1, 8'h00);
  endtask

  function automatic int exp_high(input int tgt_hi, input int db);
    int d;
    d = (db == 0) ? 0 : (1 << db);
    return (tgt_hi > d) ? (tgt_hi - d) * 10 : 0;
  endfunction

  task automatic pwm_run(input int pol, input int db, input logic [2:0] mode_lo);
    int hp = 0, hn = 0, both = 0;
    int raw_hi, exp_p, exp_n;
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'd9);
    wr(3'd2, 8'h00); wr(3'd3, 8'd4);
    wr(3'd0, 8'(db << 2));
    wr(3'd1, 8'h80 | 8'(pol << 6) | 8'(mode_lo));
    repeat (30) @(negedge clk);
    for (int i = 0; i < 90; i++) begin
      if (pwm_p) hp++;
      if (pwm_n) hn++;
      if (pwm_p && pwm_n) both++;
      @(negedge clk);
    end
    raw_hi = (mode_lo == 3'd3) ? 5 : 0;
    exp_p = exp_high(pol ? 9 - raw_hi : raw_hi, db);
    exp_n = exp_high(pol ? raw_hi : 9 - raw_hi, db);
    chk($sformatf("R4 R5 R6 pwm_p high pol=%0d db=%0d mode=%0d", pol, db, mode_lo), hp, exp_p);
    chk($sformatf("R5 R6 R11 pwm_n high pol=%0d db=%0d mode=%0d", pol, db, mode_lo), hn, exp_n);
    chk("R6 no overlap", both, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic cap_run(input logic fall);
    int c0, v;
    int seen = 0;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h03); wr(3'd5, 8'hE8);
    cap_in = fall;
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h40);            // capture-only interrupts
    wr(3'd1, 8'h84 | 8'(fall << 5));
    repeat (5) @(negedge clk);
    rd16(3'd6, c0);
    cap_in = ~fall;
    repeat (3) @(negedge clk);
    chk("R7 R8 capture irq", irq, 1);
    rd(3'd0, d); chk("R9 status after capture", d[0], 1);
    rd16(3'd2, v); chk($sformatf("R7 captured value fall=%0d", fall), v, c0 + 2);
    @(negedge clk);
    chk("R8 irq one clock", irq, 0);
    cap_in = fall;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk("R7 opposite edge no irq", seen, 0);
    rd16(3'd2, v); chk("R7 opposite edge no capture", v, c0 + 2);
    wr(3'd1, 8'h00);
  endtask

  task automatic poll_count(input int target);
    int c;
    for (int i = 0; i < 300; i++) begin
      rd16(3'd6, c);
      if (c == target) break;
      @(negedge clk);
    end
  endtask

  task automatic test_same_cycle();
    int v, found;
    logic [7:0] d;
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h00); wr(3'd5, 8'd50);
    cap_in = 1'b0;
    wr(3'd0, 8'h00);            // both sources
    wr(3'd1, 8'h84);            // capture mode, rising edge
    repeat (3) @(negedge clk);
    poll_count(48);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 coincident irq", irq, 1);
    rd(3'd0, d); chk("R9 coincident status is capture", d[0], 1);
    rd16(3'd2, v); chk("R7 coincident capture value", v, 50);
    found = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq) begin found = 1; break; end
    end
    chk("R8 plain reload irq", found, 1);
    rd(3'd0, d); chk("R9 status cleared by reload", d[0], 0);
    wr(3'd0, 8'h01);
    rd(3'd0, d); chk("R9 status write ignored", d, 0);
    wr(3'd0, 8'h60);            // reload-only
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
    poll_count(10);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 masked capture no irq", irq, 0);
    rd16(3'd2, v); chk("R7 masked capture still latches", v, 12);
    rd(3'd0, d); chk("R9 status untouched by masked capture", d[0], 0);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_staging();
    test_counter();
    pwm_run(0, 0, 3'd3);
    pwm_run(0, 1, 3'd3);
    pwm_run(0, 2, 3'd3);
    pwm_run(1, 0, 3'd3);
    pwm_run(0, 0, 3'd0);
    cap_run(1'b0);
    cap_run(1'b1);
    test_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule